// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

This block is a register-mapped timer peripheral. It holds three reloading down-counters and one wide free-running up-counter. Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each down-counter has its own start value, live count, mode settings and interrupt line. Each one advances on one of two count-enable strobes, a slow one or a fast one, chosen per channel. When a channel is ticked at zero it either restarts from its start value (periodic) or rolls over to all-ones (free-running). In both cases it raises a sticky interrupt, which software drops by writing any value to that channel's acknowledge location.

The fourth counter is 40 bits wide and only counts up. It has no interrupt and advances on its own strobe while its enable is set. Software reads it as two 32-bit words. The upper word also carries the enable bit, which is the only writable part of this counter. Clock division, bus bridging and interrupt routing sit outside the block. The tick sources arrive as single-cycle strobes, and the register port is a single-cycle write with a combinational read.

Top module: `tmr_quad_unit`

## Requirements
- R1: After reset every channel is disabled. All interrupts are low, every control and count register reads 0, and the wide counter reads 0 with its enable clear.
- R2: A write to a channel's start-value register (offset 0x0) stores the value truncated to the channel width and loads the live count at once. Offset 0x4 returns the live count and offset 0x0 returns the stored start value.
- R3: While control bit 7 is set, a channel's count drops by one on each selected tick. While bit 7 is clear, the count holds.
- R4: Control bit 3 selects the tick source: 1 selects the fast strobe and 0 selects the slow strobe. The strobe that is not selected has no effect on the count.
- R5: With control bit 6 set (periodic), a selected tick at count 0 reloads the count from the start value and sets that channel's interrupt.
- R6: With control bit 6 clear, a selected tick at count 0 sets the count to all-ones of the channel width and sets the interrupt. All-ones is 0xFFFF for 16 bits and 0xFFFFFFFF for 32 bits.
- R7: An interrupt stays set through further underflows until software writes any value to offset 0xC of that channel, which clears it. When a clear and an underflow fall in the same cycle, the interrupt stays set. irq[i] belongs to channel i: bit 0 is at 0x00, bit 1 at 0x20 and bit 2 at 0x80.
- R8: Channel bases are 0x00, 0x20 and 0x80. Within each base, offset 0x0 is the start value, 0x4 the count, 0x8 the control and 0xC the clear. The control register keeps only bits 7, 6 and 3 and reads 0 in every other bit.
- R9: The wide counter advances by one per wide strobe while enabled. Address 0x60 reads count bits 31:0. Address 0x64 reads count bits 39:32 in bits 7:0 and the enable in bit 8. A write to 0x64 sets the enable from data bit 8. When disabled, the count holds. The wide counter never touches irq.
- R10: Unmapped addresses and the clear offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_slow | input | 1 | Slow count-enable strobe for the down-counters |
| tick_fast | input | 1 | Fast count-enable strobe for the down-counters |
| tick_wide | input | 1 | Count-enable strobe for the wide up-counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 3 | Sticky underflow interrupts, one per down-counter |

## Verification
The bench builds the block with its default parameters: two 16-bit channels, one 32-bit channel and a 40-bit wide counter. With these widths the rollover values of both channel sizes can be observed directly, and so can the truncation of a 32-bit start value into a 16-bit channel. Small start values let the bench reach periodic reloads, repeated underflows against a held interrupt, and the same-cycle clear-versus-underflow race within a few ticks. The carry of the wide counter into its upper word is left to the clocked property on its increment.

// File: rtl/tmr_quad_pkg.sv
package tmr_quad_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_CH   = 3;

  localparam logic [ADDR_W-1:0] CH_BASE [NUM_CH] = '{8'h00, 8'h20, 8'h80};

  localparam logic [ADDR_W-1:0] OFF_START = 8'h0;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h4;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h8;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 8'hC;

  localparam logic [ADDR_W-1:0] WIDE_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] WIDE_HI_ADDR = 8'h64;

  localparam int BIT_RUN    = 7;
  localparam int BIT_PERIOD = 6;
  localparam int BIT_FAST   = 3;
  localparam int BIT_WIDE_EN = 8;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } ch_ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/tmr_down_channel.sv
module tmr_down_channel
  import tmr_quad_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic          start_we,
  input  logic          ctrl_we,
  input  logic          ack_we,
  input  logic [CW-1:0] start_val,
  input  ch_ctrl_t      ctrl_val,
  output logic [DW-1:0] start_rd,
  output logic [DW-1:0] count_rd,
  output ch_ctrl_t      ctrl_rd,
  output logic          irq_o
);
  logic [CW-1:0] start_q, start_d;
  logic [CW-1:0] cnt_q, cnt_d;
  ch_ctrl_t      ctrl_q, ctrl_d;
  logic          irq_q, irq_d;
  logic          tick_sel;
  logic          step;
  logic          at_zero;
  logic          uflow;

  always_comb begin
    tick_sel = ctrl_q.fast ? tick_fast : tick_slow;
    step     = ctrl_q.run && tick_sel;
    at_zero  = (cnt_q == '0);
    uflow    = step && at_zero && !start_we;

    start_d = start_q;
    cnt_d   = cnt_q;
    ctrl_d  = ctrl_q;
    irq_d   = irq_q;

    if (ctrl_we) ctrl_d = ctrl_val;

    if (start_we) begin
      start_d = start_val;
      cnt_d   = start_val;
    end else if (step) begin
      if (at_zero) cnt_d = ctrl_q.periodic ? start_q : '1;
      else         cnt_d = cnt_q - 1'b1;
    end

    if (ack_we) irq_d = 1'b0;
    if (uflow)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (start_we)          start_q <= start_d;
      if (start_we || step)  cnt_q   <= cnt_d;
      if (ctrl_we)           ctrl_q  <= ctrl_d;
      if (ack_we || uflow)   irq_q   <= irq_d;
    end
  end

  assign start_rd = DW'(start_q);
  assign count_rd = DW'(cnt_q);
  assign ctrl_rd  = ctrl_q;
  assign irq_o    = irq_q;

  p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> cnt_q == $past(start_val));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !start_we) |=> $stable(cnt_q));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && tick_sel && cnt_q == '0 && ctrl_q.periodic && !start_we)
      |=> (cnt_q == $past(start_q)) && irq_q);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && tick_sel && cnt_q == '0 && !ctrl_q.periodic && !start_we)
      |=> (&cnt_q) && irq_q);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_we) |=> irq_q);
endmodule

// File: rtl/tmr_wide_counter.sv
module tmr_wide_counter #(
  parameter int FW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_we,
  input  logic          en_val,
  output logic [FW-1:0] count_o,
  output logic          en_o
);
  logic [FW-1:0] cnt_q, cnt_d;
  logic          en_q, en_d;
  logic          adv;

  always_comb begin
    adv   = en_q && tick;
    cnt_d = cnt_q + 1'b1;
    en_d  = en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (adv)   cnt_q <= cnt_d;
      if (en_we) en_q  <= en_d;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick) |=> count_o == $past(count_o) + 1'b1);
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |=> $stable(count_o));
endmodule

// File: rtl/tmr_quad_unit.sv
module tmr_quad_unit
  import tmr_quad_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_CH_W = 32,
  parameter int WIDE_IDX = 2,
  parameter int FREE_W   = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_slow,
  input  logic        tick_fast,
  input  logic        tick_wide,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [2:0]  irq
);
  localparam int HI_W = FREE_W - DATA_W;

  logic              rst_n_int;
  logic [DATA_W-1:0] start_rd [NUM_CH];
  logic [DATA_W-1:0] count_rd [NUM_CH];
  ch_ctrl_t          ctrl_rd  [NUM_CH];
  logic [FREE_W-1:0] wide_cnt;
  logic              wide_en;
  logic              wide_we;
  ch_ctrl_t          ctrl_wval;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ctrl_wval = '{run:      reg_wdata[BIT_RUN],
                       periodic: reg_wdata[BIT_PERIOD],
                       fast:     reg_wdata[BIT_FAST]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CW = (g == WIDE_IDX) ? WIDE_CH_W : NARROW_W;
    logic sel_start, sel_ctrl, sel_ack;

    assign sel_start = reg_we && (reg_addr == CH_BASE[g] + OFF_START);
    assign sel_ctrl  = reg_we && (reg_addr == CH_BASE[g] + OFF_CTRL);
    assign sel_ack   = reg_we && (reg_addr == CH_BASE[g] + OFF_ACK);

    tmr_down_channel #(.CW(CW), .DW(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .start_we  (sel_start),
      .ctrl_we   (sel_ctrl),
      .ack_we    (sel_ack),
      .start_val (reg_wdata[CW-1:0]),
      .ctrl_val  (ctrl_wval),
      .start_rd  (start_rd[g]),
      .count_rd  (count_rd[g]),
      .ctrl_rd   (ctrl_rd[g]),
      .irq_o     (irq[g])
    );
  end

  assign wide_we = reg_we && (reg_addr == WIDE_HI_ADDR);

  tmr_wide_counter #(.FW(FREE_W)) u_wide (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick    (tick_wide),
    .en_we   (wide_we),
    .en_val  (reg_wdata[BIT_WIDE_EN]),
    .count_o (wide_cnt),
    .en_o    (wide_en)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == CH_BASE[i] + OFF_START) reg_rdata = start_rd[i];
      if (reg_addr == CH_BASE[i] + OFF_COUNT) reg_rdata = count_rd[i];
      if (reg_addr == CH_BASE[i] + OFF_CTRL) begin
        reg_rdata[BIT_RUN]    = ctrl_rd[i].run;
        reg_rdata[BIT_PERIOD] = ctrl_rd[i].periodic;
        reg_rdata[BIT_FAST]   = ctrl_rd[i].fast;
      end
    end
    if (reg_addr == WIDE_LO_ADDR) reg_rdata = wide_cnt[DATA_W-1:0];
    if (reg_addr == WIDE_HI_ADDR) begin
      reg_rdata[HI_W-1:0]   = wide_cnt[FREE_W-1:DATA_W];
      reg_rdata[BIT_WIDE_EN] = wide_en;
    end
  end

  p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_we && reg_addr == CH_BASE[0] + OFF_ACK && !tick_slow && !tick_fast)
      |=> !irq[0]);
  p_wide_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tick_wide && !tick_slow && !tick_fast) |=> ($stable(irq) || $fell(irq[0]) ||
      $fell(irq[1]) || $fell(irq[2])));
endmodule

// File: tb/tb_tmr_quad_unit.sv
module tb_tmr_quad_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 69;
  localparam logic [2:0] OW = 3'd0, ORD = 3'd1, OS = 3'd2, OF = 3'd3, OI = 3'd4, OX = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_wide = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_quad_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .tick_wide(tick_wide), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {op, addr, data, expected, requirement}
  localparam logic [78:0] VEC [NVEC] = '{
    {ORD, 8'h04, 32'h0, 32'h0, 4'd1},          // R1 count
    {ORD, 8'h08, 32'h0, 32'h0, 4'd1},          // R1 control
    {OI,  8'h00, 32'h0, 32'h0, 4'd1},          // R1 irq
    {ORD, 8'h60, 32'h0, 32'h0, 4'd1},          // R1 wide low
    {ORD, 8'h64, 32'h0, 32'h0, 4'd1},          // R1 wide high
    {OW,  8'h00, 32'h3, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h3, 4'd2},          // R2 immediate load
    {OW,  8'h08, 32'hFF, 32'h0, 4'd0},
    {ORD, 8'h08, 32'h0, 32'hC8, 4'd8},         // R8 only 7,6,3 kept
    {OS,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h3, 4'd4},          // R4 slow ignored
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h2, 4'd3},          // R3 decrement
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h0, 4'd3},          // R3 reaches zero
    {OI,  8'h00, 32'h0, 32'h0, 4'd5},          // R5 no irq at zero yet
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h3, 4'd5},          // R5 reload
    {OI,  8'h00, 32'h0, 32'h1, 4'd5},          // R5 irq set
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h3, 4'd5},          // R5 second reload
    {OI,  8'h00, 32'h0, 32'h1, 4'd7},          // R7 still set
    {OW,  8'h0C, 32'h12345678, 32'h0, 4'd0},
    {OI,  8'h00, 32'h0, 32'h0, 4'd7},          // R7 any value clears
    {OW,  8'h08, 32'h40, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h04, 32'h0, 32'h3, 4'd3},          // R3 disabled holds
    {OW,  8'h20, 32'h1, 32'h0, 4'd0},
    {OW,  8'h28, 32'h80, 32'h0, 4'd0},
    {ORD, 8'h28, 32'h0, 32'h80, 4'd8},         // R8 channel 2 control
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h24, 32'h0, 32'h1, 4'd4},          // R4 fast ignored
    {OS,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h24, 32'h0, 32'h0, 4'd3},
    {OS,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h24, 32'h0, 32'hFFFF, 4'd6},       // R6 16-bit wrap
    {OI,  8'h00, 32'h0, 32'h2, 4'd6},          // R6 irq
    {OW,  8'h80, 32'h0, 32'h0, 4'd0},
    {OW,  8'h88, 32'h88, 32'h0, 4'd0},
    {OF,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h84, 32'h0, 32'hFFFFFFFF, 4'd6},   // R6 32-bit wrap
    {OI,  8'h00, 32'h0, 32'h6, 4'd6},
    {OW,  8'h8C, 32'h0, 32'h0, 4'd0},
    {OI,  8'h00, 32'h0, 32'h2, 4'd7},          // R7 per-channel clear
    {OW,  8'h2C, 32'h0, 32'h0, 4'd0},
    {OI,  8'h00, 32'h0, 32'h0, 4'd7},
    {OW,  8'h80, 32'hDEADBEEF, 32'h0, 4'd0},
    {ORD, 8'h84, 32'h0, 32'hDEADBEEF, 4'd2},   // R2 32-bit load
    {OW,  8'h20, 32'h00012345, 32'h0, 4'd0},
    {ORD, 8'h20, 32'h0, 32'h2345, 4'd2},       // R2 truncation
    {ORD, 8'h00, 32'h0, 32'h3, 4'd8},          // R8 start readback
    {ORD, 8'h40, 32'h0, 32'h0, 4'd10},         // R10 unmapped
    {ORD, 8'h0C, 32'h0, 32'h0, 4'd10},         // R10 clear reads 0
    {OX,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h60, 32'h0, 32'h0, 4'd9},          // R9 disabled
    {OW,  8'h64, 32'h100, 32'h0, 4'd0},
    {ORD, 8'h64, 32'h0, 32'h100, 4'd9},        // R9 enable readback
    {OX,  8'h00, 32'h0, 32'h0, 4'd0},
    {OX,  8'h00, 32'h0, 32'h0, 4'd0},
    {OX,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h60, 32'h0, 32'h3, 4'd9},          // R9 counts
    {OW,  8'h64, 32'h0, 32'h0, 4'd0},
    {OX,  8'h00, 32'h0, 32'h0, 4'd0},
    {ORD, 8'h60, 32'h0, 32'h3, 4'd9},          // R9 holds
    {OI,  8'h00, 32'h0, 32'h0, 4'd9}           // R9 no irq
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycle_op(input logic [2:0] op, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    case (op)
      OW: begin reg_addr = a; reg_wdata = d; reg_we = 1'b1; end
      OS: tick_slow = 1'b1;
      OF: tick_fast = 1'b1;
      OX: tick_wide = 1'b1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    reg_we = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; tick_wide = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NVEC; k++) begin
      logic [2:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      int          rq;
      {op, a, d, e} = VEC[k][78:4];
      rq = int'(VEC[k][3:0]);
      if (op == ORD) begin
        reg_addr = a; #2; check(reg_rdata, e, rq);
      end else if (op == OI) begin
        #2; check({29'd0, irq}, e, rq);
      end else begin
        cycle_op(op, a, d);
      end
    end

    // R7: clear and underflow in the same cycle, underflow wins
    cycle_op(OW, 8'h00, 32'h0);
    cycle_op(OW, 8'h08, 32'hC8);
    @(negedge clk);
    reg_addr = 8'h0C; reg_wdata = 32'h5; reg_we = 1'b1; tick_fast = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; tick_fast = 1'b0;
    #2; check({29'd0, irq}, 32'h1, 7);   // R7 race
    cycle_op(OW, 8'h0C, 32'h0);
    #2; check({29'd0, irq}, 32'h0, 7);   // R7 clear afterwards

    // R1: reset in the middle of activity
    cycle_op(OF, 8'h00, 32'h0);
    #2; rst_n = 1'b0; #2;
    check({29'd0, irq}, 32'h0, 1);       // R1 irq after reset
    reg_addr = 8'h08; #1; check(reg_rdata, 32'h0, 1);
    reg_addr = 8'h60; #1; check(reg_rdata, 32'h0, 1);
    reg_addr = 8'h84; #1; check(reg_rdata, 32'h0, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule